// File: doc/BRIEF.md
# Truth Table Composition Engine

This block builds the truth table of a composed single-bit function. Each function is a 64-entry table over at most six shared input variables, and a small mask records which of those variables it depends on. One table is kept for each bit position of a data word. The engine takes two operands and a two-operand operation from a built-in library. Each operand is either the table of an earlier result or a direct reference to one input variable. The engine produces the table of the operation applied to the two operand functions.

The engine steps through the input combinations, one per clock cycle. For each combination it reads one bit from each operand. It places those bits, together with a carry-in bit, into a three-bit index and reads the operation's own eight-entry table at that index. Addition brings in a new variable for its incoming carry and gives the lowest-numbered variable that neither operand uses. For addition, a second table is produced for the carry output. The engine also reports the variable mask of the result and its input count, and marks the result invalid when more than six variables would be needed. Control uses a start/done handshake. Operands are captured at start, and results stay stable from done until the next accepted start.

Top module: `tt_compose_engine`

## Requirements
- R1: An operand in table mode gives bit i of its supplied table for combination i. An operand in direct mode with selection k gives bit k of i, and its variable mask has only bit k set.
- R2: For combination i, the result bit equals entry {cin, b, a} of the operation table. Here a (the LSB) and b are the operand bits for i, and cin is the carry-variable bit, or 0 when no carry is added.
- R3: When the input count exceeds 6, the engine raises overflow and clears the valid flag.
- R4: The operation codes are 0 = AND, 1 = OR, 2 = XOR and 3 = ADD. For ADD, the main table is the sum (three-input XOR of a, b and cin) and the carry table is the majority of a, b and cin.
- R5: ADD gives the carry-in the lowest-numbered variable that is not in the union of the operand masks. The bit of that variable in i is cin for combination i, and the result mask includes that variable.
- R6: The input count equals the number of variables in the union of the operand masks, plus one when ADD adds its carry.
- R7: For the operations other than ADD, the carry flag is low and the carry table is all zeros.
- R8: After the start edge, busy stays high for 64 cycles. Then done is high for exactly one cycle, and the results are final in that cycle.
- R9: A start asserted while busy has no effect on the running composition or on its results.
- R10: A direct-mode selection of 6 or 7 clears the valid flag and leaves overflow low.
- R11: After reset, busy, done, valid, overflow and the carry flag are low, and both tables, the mask and the count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a composition (accepted only when idle) |
| op_code | input | 2 | Operation: 0 AND, 1 OR, 2 XOR, 3 ADD |
| a_direct | input | 1 | Operand A is a direct variable (1) or a table (0) |
| a_sel | input | 3 | Variable number for direct operand A |
| a_table | input | 64 | Truth table of operand A |
| a_mask | input | 6 | Variables that table operand A depends on |
| b_direct | input | 1 | Operand B is a direct variable (1) or a table (0) |
| b_sel | input | 3 | Variable number for direct operand B |
| b_table | input | 64 | Truth table of operand B |
| b_mask | input | 6 | Variables that table operand B depends on |
| busy | output | 1 | Composition in progress |
| done | output | 1 | One-cycle completion pulse |
| res_table | output | 64 | Composed main truth table |
| res_carry_table | output | 64 | Composed carry-out truth table |
| res_mask | output | 6 | Variables of the composed function |
| res_count | output | 3 | Input count of the composed function |
| res_has_carry | output | 1 | Operation produces a carry table |
| res_overflow | output | 1 | More than six variables were needed |
| res_valid | output | 1 | Result is usable |

## Verification
The bench sweeps every pair of direct variables under every operation, including pairs where both operands use the same variable. A design that swapped the operand order in the lookup index, or that counted a shared variable twice, would produce wrong tables or a wrong count. It runs ADD with operand masks that leave exactly one free variable, no free variable, and holes at different positions. An allocator that picked the wrong free variable would move the carry columns, and one that missed a full union would report a valid seven-input function. It also asserts start in the middle of a run and uses out-of-range direct selections. A design that restarted on a busy start would finish late with mixed tables, and one that ignored a bad selection would report a valid result.

// File: rtl/tt_compose_pkg.sv
package tt_compose_pkg;

  typedef enum logic [1:0] {
    OP_AND = 2'd0,
    OP_OR  = 2'd1,
    OP_XOR = 2'd2,
    OP_ADD = 2'd3
  } tt_op_e;

  // Eight-entry library tables indexed by {cin, b, a}
  localparam logic [7:0] LUT_AND   = 8'h88;
  localparam logic [7:0] LUT_OR    = 8'hEE;
  localparam logic [7:0] LUT_XOR   = 8'h66;
  localparam logic [7:0] LUT_SUM   = 8'h96;
  localparam logic [7:0] LUT_MAJ   = 8'hE8;
  localparam logic [7:0] LUT_ZERO  = 8'h00;

  function automatic logic [2:0] fn_lut_index(input logic a, input logic b, input logic c);
    return {c, b, a};
  endfunction

  function automatic logic [7:0] fn_main_lut(input tt_op_e op);
    case (op)
      OP_AND:  return LUT_AND;
      OP_OR:   return LUT_OR;
      OP_XOR:  return LUT_XOR;
      default: return LUT_SUM;
    endcase
  endfunction

  function automatic logic [7:0] fn_carry_lut(input tt_op_e op);
    return (op == OP_ADD) ? LUT_MAJ : LUT_ZERO;
  endfunction

  function automatic logic fn_adds_carry(input tt_op_e op);
    return op == OP_ADD;
  endfunction

endpackage

// File: rtl/tt_operand_src.sv
module tt_operand_src #(
  parameter int NVAR  = 6,
  parameter int DEPTH = 1 << NVAR,
  parameter int SEL_W = (NVAR > 1) ? $clog2(NVAR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             in_direct,
  input  logic [SEL_W-1:0] in_sel,
  input  logic [DEPTH-1:0] in_table,
  input  logic [NVAR-1:0]  in_mask,
  input  logic [NVAR-1:0]  idx,
  output logic             op_bit,
  output logic [NVAR-1:0]  op_mask,
  output logic             op_sel_ok
);

  localparam logic [NVAR-1:0] ONE_HOT0 = {{(NVAR-1){1'b0}}, 1'b1};

  logic             direct_q;
  logic [SEL_W-1:0] sel_q;
  logic [DEPTH-1:0] table_q;
  logic [NVAR-1:0]  mask_q;
  logic             sel_in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      direct_q <= 1'b0;
      sel_q    <= '0;
      table_q  <= '0;
      mask_q   <= '0;
    end else if (load) begin
      direct_q <= in_direct;
      sel_q    <= in_sel;
      table_q  <= in_table;
      mask_q   <= in_mask;
    end
  end

  assign sel_in_range = ({1'b0, sel_q} < (SEL_W+1)'(NVAR));
  assign op_sel_ok    = !direct_q || sel_in_range;

  always_comb begin
    op_bit  = 1'b0;
    op_mask = '0;
    if (direct_q) begin
      if (sel_in_range) begin
        op_bit  = idx[sel_q];
        op_mask = ONE_HOT0 << sel_q;
      end
    end else begin
      op_bit  = table_q[idx];
      op_mask = mask_q;
    end
  end

endmodule

// File: rtl/tt_op_library.sv
module tt_op_library
  import tt_compose_pkg::*;
(
  input  tt_op_e     op,
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       c_bit,
  output logic       main_bit,
  output logic       carry_bit,
  output logic       adds_carry
);

  logic [2:0] lut_idx;
  logic [7:0] main_lut;
  logic [7:0] carry_lut;

  assign lut_idx    = fn_lut_index(a_bit, b_bit, c_bit);
  assign main_lut   = fn_main_lut(op);
  assign carry_lut  = fn_carry_lut(op);
  assign adds_carry = fn_adds_carry(op);
  assign main_bit   = main_lut[lut_idx];
  assign carry_bit  = carry_lut[lut_idx];

endmodule

// File: rtl/tt_var_alloc.sv
module tt_var_alloc #(
  parameter int NVAR  = 6,
  parameter int CNT_W = $clog2(NVAR + 2),
  parameter int VAR_W = (NVAR > 1) ? $clog2(NVAR) : 1
) (
  input  logic [NVAR-1:0]  mask_a,
  input  logic [NVAR-1:0]  mask_b,
  input  logic             need_carry,
  output logic [NVAR-1:0]  out_mask,
  output logic [CNT_W-1:0] out_count,
  output logic [VAR_W-1:0] carry_var,
  output logic             carry_found,
  output logic             overflow
);

  logic [NVAR-1:0]  uni;
  logic [CNT_W-1:0] uni_count;

  assign uni = mask_a | mask_b;

  always_comb begin
    uni_count   = '0;
    carry_var   = '0;
    carry_found = 1'b0;
    for (int v = 0; v < NVAR; v++) begin
      uni_count = uni_count + CNT_W'(uni[v]);
    end
    for (int v = NVAR - 1; v >= 0; v--) begin
      if (!uni[v]) begin
        carry_var   = VAR_W'(v);
        carry_found = 1'b1;
      end
    end
  end

  always_comb begin
    out_mask = uni;
    if (need_carry && carry_found) out_mask[carry_var] = 1'b1;
  end

  assign out_count = uni_count + CNT_W'(need_carry);
  assign overflow  = need_carry && !carry_found;

endmodule

// File: rtl/tt_seq_ctrl.sv
module tt_seq_ctrl #(
  parameter int NVAR = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            load,
  output logic            busy,
  output logic            step_en,
  output logic            step_last,
  output logic [NVAR-1:0] idx,
  output logic            done
);

  localparam logic [NVAR-1:0] IDX_LAST = '1;

  assign load      = start && !busy;
  assign step_en   = busy;
  assign step_last = busy && (idx == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        if (step_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tt_compose_engine.sv
module tt_compose_engine
  import tt_compose_pkg::*;
#(
  parameter int NVAR  = 6,
  parameter int DEPTH = 1 << NVAR,
  parameter int SEL_W = (NVAR > 1) ? $clog2(NVAR) : 1,
  parameter int CNT_W = $clog2(NVAR + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op_code,
  input  logic             a_direct,
  input  logic [SEL_W-1:0] a_sel,
  input  logic [DEPTH-1:0] a_table,
  input  logic [NVAR-1:0]  a_mask,
  input  logic             b_direct,
  input  logic [SEL_W-1:0] b_sel,
  input  logic [DEPTH-1:0] b_table,
  input  logic [NVAR-1:0]  b_mask,
  output logic             busy,
  output logic             done,
  output logic [DEPTH-1:0] res_table,
  output logic [DEPTH-1:0] res_carry_table,
  output logic [NVAR-1:0]  res_mask,
  output logic [CNT_W-1:0] res_count,
  output logic             res_has_carry,
  output logic             res_overflow,
  output logic             res_valid
);

  // Named internal events, visible to the bound checker
  logic            load;
  logic            step_en;
  logic            step_last;
  logic [NVAR-1:0] idx;

  tt_op_e op_q;

  logic [1:0]            opnd_direct [2];
  logic [SEL_W-1:0]      opnd_sel    [2];
  logic [DEPTH-1:0]      opnd_table  [2];
  logic [NVAR-1:0]       opnd_mask_i [2];
  logic [1:0]            opnd_bit;
  logic [NVAR-1:0]       opnd_mask   [2];
  logic [1:0]            opnd_ok;

  logic                  adds_carry;
  logic                  carry_found;
  logic [SEL_W-1:0]      carry_var;
  logic                  cin_bit;
  logic                  main_bit;
  logic                  carry_bit;

  tt_seq_ctrl #(.NVAR(NVAR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load      (load),
    .busy      (busy),
    .step_en   (step_en),
    .step_last (step_last),
    .idx       (idx),
    .done      (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    op_q <= OP_AND;
    else if (load) op_q <= tt_op_e'(op_code);
  end

  assign opnd_direct[0] = {1'b0, a_direct};
  assign opnd_direct[1] = {1'b0, b_direct};
  assign opnd_sel[0]    = a_sel;
  assign opnd_sel[1]    = b_sel;
  assign opnd_table[0]  = a_table;
  assign opnd_table[1]  = b_table;
  assign opnd_mask_i[0] = a_mask;
  assign opnd_mask_i[1] = b_mask;

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    tt_operand_src #(.NVAR(NVAR), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .in_direct (opnd_direct[g][0]),
      .in_sel    (opnd_sel[g]),
      .in_table  (opnd_table[g]),
      .in_mask   (opnd_mask_i[g]),
      .idx       (idx),
      .op_bit    (opnd_bit[g]),
      .op_mask   (opnd_mask[g]),
      .op_sel_ok (opnd_ok[g])
    );
  end

  tt_var_alloc #(.NVAR(NVAR), .CNT_W(CNT_W), .VAR_W(SEL_W)) u_alloc (
    .mask_a      (opnd_mask[0]),
    .mask_b      (opnd_mask[1]),
    .need_carry  (adds_carry),
    .out_mask    (res_mask),
    .out_count   (res_count),
    .carry_var   (carry_var),
    .carry_found (carry_found),
    .overflow    (res_overflow)
  );

  assign cin_bit = adds_carry && carry_found && idx[carry_var];

  tt_op_library u_lib (
    .op         (op_q),
    .a_bit      (opnd_bit[0]),
    .b_bit      (opnd_bit[1]),
    .c_bit      (cin_bit),
    .main_bit   (main_bit),
    .carry_bit  (carry_bit),
    .adds_carry (adds_carry)
  );

  assign res_has_carry = adds_carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_table       <= '0;
      res_carry_table <= '0;
      res_valid       <= 1'b0;
    end else if (load) begin
      res_table       <= '0;
      res_carry_table <= '0;
      res_valid       <= 1'b0;
    end else if (step_en) begin
      res_table[idx]       <= main_bit;
      res_carry_table[idx] <= carry_bit;
      if (step_last) res_valid <= !res_overflow && (&opnd_ok);
    end
  end

endmodule

// File: rtl/tt_compose_checker.sv
module tt_compose_checker #(
  parameter int NVAR  = 6,
  parameter int DEPTH = 1 << NVAR,
  parameter int CNT_W = $clog2(NVAR + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             load,
  input logic             busy,
  input logic             done,
  input logic             step_last,
  input logic [DEPTH-1:0] res_carry_table,
  input logic [NVAR-1:0]  res_mask,
  input logic [CNT_W-1:0] res_count,
  input logic             res_has_carry,
  input logic             res_overflow,
  input logic             res_valid
);

  logic [NVAR:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (load) run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == (NVAR+1)'(DEPTH))); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    res_overflow |-> !res_valid); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_count <= CNT_W'(NVAR))); // R3
  AST_MASK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_overflow) |-> ($countones(res_mask) == int'(res_count))); // R6
  AST_CARRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_has_carry) |-> (res_carry_table == '0)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step_last) |=> (busy && $stable(res_mask))); // R9

endmodule

bind tt_compose_engine tt_compose_checker #(.NVAR(NVAR), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start           (start),
  .load            (load),
  .busy            (busy),
  .done            (done),
  .step_last       (step_last),
  .res_carry_table (res_carry_table),
  .res_mask        (res_mask),
  .res_count       (res_count),
  .res_has_carry   (res_has_carry),
  .res_overflow    (res_overflow),
  .res_valid       (res_valid)
);

// File: tb/tt_compose_engine_tb.sv
module tt_compose_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_code = '0;
  logic        a_direct = 1'b0, b_direct = 1'b0;
  logic [2:0]  a_sel = '0, b_sel = '0;
  logic [63:0] a_table = '0, b_table = '0;
  logic [5:0]  a_mask = '0, b_mask = '0;
  logic        busy, done;
  logic [63:0] res_table, res_carry_table;
  logic [5:0]  res_mask;
  logic [2:0]  res_count;
  logic        res_has_carry, res_overflow, res_valid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tt_compose_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .a_direct(a_direct), .a_sel(a_sel), .a_table(a_table), .a_mask(a_mask),
    .b_direct(b_direct), .b_sel(b_sel), .b_table(b_table), .b_mask(b_mask),
    .busy(busy), .done(done), .res_table(res_table), .res_carry_table(res_carry_table),
    .res_mask(res_mask), .res_count(res_count), .res_has_carry(res_has_carry),
    .res_overflow(res_overflow), .res_valid(res_valid)
  );

  task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Reference arithmetic for one combination
  function automatic logic ref_bit(input int op, input int a, input int b, input int c, input bit want_carry);
    int s;
    s = a + b + c;
    if (want_carry) return (op == 3) && (s >= 2);
    case (op)
      0: return logic'(a * b);
      1: return logic'((a + b) > 0);
      2: return logic'((a + b) == 1);
      default: return logic'(s % 2);
    endcase
  endfunction

  task automatic run_job(input int op, input bit ad, input int asel, input logic [63:0] atab, input logic [5:0] amsk,
                         input bit bd, input int bsel, input logic [63:0] btab, input logic [5:0] bmsk,
                         input bit disturb);
    logic [63:0] exp_main, exp_carry;
    logic [5:0]  ma, mb, uni, exp_mask;
    int          cv, cnt, cycles;
    bit          bad_sel, need_c, exp_ovf;
    @(negedge clk);
    op_code = 2'(op); a_direct = ad; a_sel = 3'(asel); a_table = atab; a_mask = amsk;
    b_direct = bd; b_sel = 3'(bsel); b_table = btab; b_mask = bmsk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bad_sel = (ad && asel > 5) || (bd && bsel > 5);
    ma = ad ? ((asel < 6) ? 6'(1 << asel) : 6'd0) : amsk;
    mb = bd ? ((bsel < 6) ? 6'(1 << bsel) : 6'd0) : bmsk;
    uni = ma | mb;
    need_c = (op == 3);
    cv = -1;
    for (int v = 5; v >= 0; v--) if (!uni[v]) cv = v;
    exp_ovf = need_c && (cv < 0);
    exp_mask = uni;
    if (need_c && cv >= 0) exp_mask[cv] = 1'b1;
    cnt = need_c ? 1 : 0;
    for (int v = 0; v < 6; v++) cnt += int'(uni[v]);
    for (int i = 0; i < 64; i++) begin
      int abit, bbit, cbit;
      abit = ad ? ((asel < 6) ? (i >> asel) % 2 : 0) : int'(atab[i]);
      bbit = bd ? ((bsel < 6) ? (i >> bsel) % 2 : 0) : int'(btab[i]);
      cbit = (need_c && cv >= 0) ? (i >> cv) % 2 : 0;
      exp_main[i]  = ref_bit(op, abit, bbit, cbit, 1'b0);
      exp_carry[i] = ref_bit(op, abit, bbit, cbit, 1'b1);
    end
    cycles = 1;
    while (!done && cycles < 300) begin
      if (disturb && cycles == 10) begin
        op_code = 2'(op ^ 1); a_direct = ~ad; b_table = ~btab; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cycles++;
    end
    start = 1'b0;
    check("R8", "cycles start to done", 64'(cycles), 64'd65);
    check("R2", "main table", res_table, exp_main);
    check("R4", "carry table", res_carry_table, exp_carry);
    check("R5", "result mask", 64'(res_mask), 64'(exp_mask));
    check("R6", "input count", 64'(res_count), 64'(cnt));
    check("R3", "overflow", 64'(res_overflow), 64'(exp_ovf));
    check("R10", "valid", 64'(res_valid), 64'(!exp_ovf && !bad_sel));
    check("R7", "has carry", 64'(res_has_carry), 64'(need_c));
    if (disturb) check("R9", "busy start ignored, table intact", res_table, exp_main);
    @(negedge clk);
    check("R8", "done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "busy", 64'(busy), 0);
    check("R11", "done", 64'(done), 0);
    check("R11", "valid", 64'(res_valid), 0);
    check("R11", "tables", res_table | res_carry_table, 0);
    check("R11", "mask/count/flags", {res_mask, res_count, res_overflow, res_has_carry}, 0);
    rst_n = 1'b1;
    // R1 R2 R4: every direct variable pair under every operation
    for (int op = 0; op < 4; op++)
      for (int ka = 0; ka < 6; ka++)
        for (int kb = 0; kb < 6; kb++)
          run_job(op, 1'b1, ka, 64'h0, 6'h0, 1'b1, kb, 64'h0, 6'h0, 1'b0);
    // R1: table operands with assorted masks
    for (int op = 0; op < 4; op++) begin
      run_job(op, 1'b0, 0, 64'hA5F0_3C96_0FF1_7E24, 6'h0F, 1'b0, 0, 64'h1234_5678_9ABC_DEF0, 6'h13, 1'b0);
      run_job(op, 1'b0, 0, 64'hFFFF_0000_FFFF_0000, 6'h10, 1'b1, 2, 64'h0, 6'h0, 1'b0);
    end
    // R5: one free variable at various positions, R3 with none free
    for (int hole = 0; hole < 6; hole++)
      run_job(3, 1'b0, 0, 64'hC3A5_5A3C_9966_6699, 6'(6'h3F & ~(1 << hole)), 1'b0, 0,
              64'h0F0F_F0F0_3333_CCCC, 6'h00, 1'b0);
    run_job(3, 1'b0, 0, 64'h0123_4567_89AB_CDEF, 6'h3F, 1'b0, 0, 64'hFEDC_BA98_7654_3210, 6'h00, 1'b0);
    run_job(0, 1'b0, 0, 64'h0123_4567_89AB_CDEF, 6'h3F, 1'b0, 0, 64'hFEDC_BA98_7654_3210, 6'h21, 1'b0);
    // R10: out-of-range direct selections
    run_job(2, 1'b1, 6, 64'h0, 6'h0, 1'b1, 1, 64'h0, 6'h0, 1'b0);
    run_job(3, 1'b1, 0, 64'h0, 6'h0, 1'b1, 7, 64'h0, 6'h0, 1'b0);
    // R9: start while busy
    run_job(3, 1'b1, 1, 64'h0, 6'h0, 1'b0, 0, 64'h5555_AAAA_3333_CCCC, 6'h25, 1'b1);
    run_job(1, 1'b0, 0, 64'h8421_1248_F00F_0FF0, 6'h3F, 1'b1, 4, 64'h0, 6'h0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule